// File: doc/BRIEF.md
# Split-Capable Auto-Reload Timer with Capture

This block is a timer peripheral with a small register bus. It holds a 16-bit count and a 16-bit reload value. It can run as one 16-bit counter or as two independent 8-bit counters, and in both cases a counter that wraps reloads itself from the reload register. Each timebase is either the system clock divided by 12 or an external clock divided by 8. A per-byte pin can select the undivided system clock instead. The external clock is synchronized into the system clock domain before it is used.

A rising edge on a comparator input can copy the running count into the reload register, which allows period or pulse measurement. The block keeps two sticky overflow flags and drives one level interrupt request. That request is gated by an enable pin that stands in for the global interrupt enable. Software reads and writes all state through an 8-bit bus with a 3-bit address. A write takes effect on the clock edge on which `bus_wr` is sampled high. Reads are combinational from `bus_addr`.

Top module: `split_reload_timer`

## Requirements
- R1: After reset, every register reads 0x00 and `irq` is low.
- R2: Address 0 is the control register. Bit 7 is the high overflow flag, bit 6 the low overflow flag, bit 5 the low interrupt enable, bit 4 capture enable, bit 3 split mode, bit 2 run, and bit 0 external clock select. Bit 1 always reads 0.
- R3: In 16-bit mode (bit 3 = 0), each step adds one to {count high, count low}. A step from 0xFFFF loads the 16-bit reload value and sets both flags. A step that takes the low byte past 0xFF sets the low flag.
- R4: In split mode, each byte steps on its own. A byte stepping from 0xFF loads its own reload byte. A low wrap sets only bit 6 and a high wrap sets only bit 7.
- R5: In 16-bit mode the run bit enables the whole counter. In split mode it enables only the high byte, and the low byte steps whether the run bit is set or not.
- R6: Only software writes clear the flags. When a hardware set and a software write of the same flag fall on the same edge, the flag ends up set.
- R7: When bit 4 is set, a synchronized rising edge of `cmp_in` copies the 16-bit count into the reload register and pulses `irq` for one cycle. When bit 4 is clear, the edge leaves the reload register unchanged and raises no request.
- R8: `irq` = `irq_global_en` AND (high flag OR (low flag AND bit 5) OR capture pulse).
- R9: With bit 0 = 0 the timebase ticks once every 12 system cycles. With bit 0 = 1 it ticks once per 8 synchronized rising edges of `ext_clk`.
- R10: When `lo_sys_sel` is high, the low byte (or the whole counter in 16-bit mode) steps on every system cycle. When `hi_sys_sel` is high, the split high byte does the same. When either pin is low, that byte uses the timebase.
- R11: A software write to a count byte overrides that cycle's step. In 16-bit mode it cancels the whole step and sets no flag.
- R12: The address map is: 1 count low, 2 count high, 3 reload low, 4 reload high. Each of these is read/write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External clock source, asynchronous |
| cmp_in | input | 1 | Comparator output used as capture trigger, asynchronous |
| irq_global_en | input | 1 | Global interrupt enable |
| lo_sys_sel | input | 1 | Low byte / 16-bit counter uses the undivided system clock |
| hi_sys_sel | input | 1 | Split high byte uses the undivided system clock |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a hardware flag set that falls on the same edge as a software write clearing that flag. Bus writes are single-cycle and the count advances every cycle, so the bench places a wrap exactly on the edge of the write that stops the run. It loads 0xFFFE and runs for exactly two steps. Prescaler rates are checked over run windows of a whole number of tick periods. This makes the count delta exact whatever the prescaler phase. Capture is checked with the counter stopped, so the captured value is known.

// File: rtl/srt_pkg.sv
package srt_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd4;

  // control bit positions; software decodes these
  localparam int B_HFLAG = 7;
  localparam int B_LFLAG = 6;
  localparam int B_LIE   = 5;
  localparam int B_CAPEN = 4;
  localparam int B_SPLIT = 3;
  localparam int B_RUN   = 2;
  localparam int B_XSEL  = 0;

  typedef struct packed {
    logic hflag;
    logic lflag;
    logic lie;
    logic cap_en;
    logic split;
    logic run;
    logic xsel;
  } ctrl_t;
endpackage

// File: rtl/srt_edge_sync.sv
module srt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-1:0], din};
  end

  // sr_q[STAGES-1] is the last synchronizer stage, sr_q[STAGES] its delayed copy
  assign rise = sr_q[STAGES-1] & ~sr_q[STAGES];
endmodule

// File: rtl/srt_prescaler.sv
module srt_prescaler #(
  parameter int SYS_DIV = 12,
  parameter int EXT_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_rise,
  input  logic sel_ext,
  output logic base_tick
);
  localparam int SW = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;
  localparam int EW = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;
  localparam logic [SW-1:0] S_LAST = SW'(SYS_DIV - 1);
  localparam logic [EW-1:0] E_LAST = EW'(EXT_DIV - 1);

  logic [SW-1:0] scnt_q;
  logic [EW-1:0] ecnt_q;
  logic          s_wrap, e_wrap;

  assign s_wrap = (scnt_q == S_LAST);
  assign e_wrap = ext_rise && (ecnt_q == E_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt_q <= '0;
      ecnt_q <= '0;
    end else begin
      scnt_q <= s_wrap ? '0 : scnt_q + 1'b1;
      if (ext_rise) ecnt_q <= (ecnt_q == E_LAST) ? '0 : ecnt_q + 1'b1;
    end
  end

  assign base_tick = sel_ext ? e_wrap : s_wrap;
endmodule

// File: rtl/srt_count_core.sv
module srt_count_core #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            split,
  input  logic            run,
  input  logic            lo_tick,
  input  logic            hi_tick,
  input  logic            wr_cnt_lo,
  input  logic            wr_cnt_hi,
  input  logic            wr_rld_lo,
  input  logic            wr_rld_hi,
  input  logic [BW-1:0]   wdata,
  input  logic            capture,
  output logic [2*BW-1:0] cnt,
  output logic [2*BW-1:0] rld,
  output logic            set_lf,
  output logic            set_hf
);
  localparam int CW = 2 * BW;
  localparam logic [BW-1:0] BMAX = '1;
  localparam logic [CW-1:0] WMAX = '1;

  logic [BW-1:0] lo_q, hi_q, rlo_q, rhi_q;
  logic          lo_step8, hi_step8, step16;
  logic          lo_end, hi_end, full_end;

  assign lo_end   = (lo_q == BMAX);
  assign hi_end   = (hi_q == BMAX);
  assign full_end = ({hi_q, lo_q} == WMAX);

  // split: low byte free-running, high byte gated by run
  assign lo_step8 = split && lo_tick && !wr_cnt_lo;
  assign hi_step8 = split && run && hi_tick && !wr_cnt_hi;
  // 16-bit: any count write cancels the whole step
  assign step16   = !split && run && lo_tick && !wr_cnt_lo && !wr_cnt_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_cnt_lo)     lo_q <= wdata;
      else if (lo_step8) lo_q <= lo_end ? rlo_q : lo_q + 1'b1;
      else if (step16)   lo_q <= full_end ? rlo_q : lo_q + 1'b1;

      if (wr_cnt_hi)     hi_q <= wdata;
      else if (hi_step8) hi_q <= hi_end ? rhi_q : hi_q + 1'b1;
      else if (step16)   hi_q <= full_end ? rhi_q : (lo_end ? hi_q + 1'b1 : hi_q);
    end
  end

  // capture outranks a software reload write on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rlo_q <= '0;
      rhi_q <= '0;
    end else if (capture) begin
      rlo_q <= lo_q;
      rhi_q <= hi_q;
    end else begin
      if (wr_rld_lo) rlo_q <= wdata;
      if (wr_rld_hi) rhi_q <= wdata;
    end
  end

  assign set_lf = (lo_step8 && lo_end) || (step16 && lo_end);
  assign set_hf = (hi_step8 && hi_end) || (step16 && full_end);
  assign cnt    = {hi_q, lo_q};
  assign rld    = {rhi_q, rlo_q};
endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer
  import srt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SYS_DIV     = 12,
  parameter int EXT_DIV     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic              cmp_in,
  input  logic              irq_global_en,
  input  logic              lo_sys_sel,
  input  logic              hi_sys_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int CW = 2 * BUS_W;

  ctrl_t            ctrl_q;
  logic             wr_ctrl, wr_cnt_lo, wr_cnt_hi, wr_rld_lo, wr_rld_hi;
  logic             ext_rise, cap_rise, capture, cap_q;
  logic             base_tick, lo_tick, hi_tick;
  logic             set_lf, set_hf;
  logic [CW-1:0]    cnt, rld;

  assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
  assign wr_cnt_lo = bus_wr && (bus_addr == A_CNT_LO);
  assign wr_cnt_hi = bus_wr && (bus_addr == A_CNT_HI);
  assign wr_rld_lo = bus_wr && (bus_addr == A_RLD_LO);
  assign wr_rld_hi = bus_wr && (bus_addr == A_RLD_HI);

  srt_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_clk), .rise(ext_rise)
  );

  srt_edge_sync #(.STAGES(SYNC_STAGES)) u_cmp_sync (
    .clk(clk), .rst_n(rst_n), .din(cmp_in), .rise(cap_rise)
  );

  srt_prescaler #(.SYS_DIV(SYS_DIV), .EXT_DIV(EXT_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .ext_rise(ext_rise),
    .sel_ext(ctrl_q.xsel), .base_tick(base_tick)
  );

  assign lo_tick = lo_sys_sel ? 1'b1 : base_tick;
  assign hi_tick = hi_sys_sel ? 1'b1 : base_tick;
  assign capture = ctrl_q.cap_en && cap_rise;

  srt_count_core #(.BW(BUS_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .split(ctrl_q.split), .run(ctrl_q.run),
    .lo_tick(lo_tick), .hi_tick(hi_tick),
    .wr_cnt_lo(wr_cnt_lo), .wr_cnt_hi(wr_cnt_hi),
    .wr_rld_lo(wr_rld_lo), .wr_rld_hi(wr_rld_hi),
    .wdata(bus_wdata), .capture(capture),
    .cnt(cnt), .rld(rld), .set_lf(set_lf), .set_hf(set_hf)
  );

  // control register; a hardware flag set beats a software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cap_q  <= 1'b0;
    end else begin
      cap_q <= capture;
      if (wr_ctrl) begin
        ctrl_q.lie    <= bus_wdata[B_LIE];
        ctrl_q.cap_en <= bus_wdata[B_CAPEN];
        ctrl_q.split  <= bus_wdata[B_SPLIT];
        ctrl_q.run    <= bus_wdata[B_RUN];
        ctrl_q.xsel   <= bus_wdata[B_XSEL];
      end
      if (set_hf)       ctrl_q.hflag <= 1'b1;
      else if (wr_ctrl) ctrl_q.hflag <= bus_wdata[B_HFLAG];
      if (set_lf)       ctrl_q.lflag <= 1'b1;
      else if (wr_ctrl) ctrl_q.lflag <= bus_wdata[B_LFLAG];
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL: begin
        bus_rdata[B_HFLAG] = ctrl_q.hflag;
        bus_rdata[B_LFLAG] = ctrl_q.lflag;
        bus_rdata[B_LIE]   = ctrl_q.lie;
        bus_rdata[B_CAPEN] = ctrl_q.cap_en;
        bus_rdata[B_SPLIT] = ctrl_q.split;
        bus_rdata[B_RUN]   = ctrl_q.run;
        bus_rdata[B_XSEL]  = ctrl_q.xsel;
      end
      A_CNT_LO: bus_rdata = cnt[BUS_W-1:0];
      A_CNT_HI: bus_rdata = cnt[CW-1:BUS_W];
      A_RLD_LO: bus_rdata = rld[BUS_W-1:0];
      A_RLD_HI: bus_rdata = rld[CW-1:BUS_W];
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = irq_global_en &&
               (ctrl_q.hflag || (ctrl_q.lflag && ctrl_q.lie) || cap_q);
endmodule

// File: rtl/split_reload_timer_chk.sv
module split_reload_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          irq_global_en,
  input logic          hflag,
  input logic          split,
  input logic          run,
  input logic          cap_en,
  input logic          lo_tick,
  input logic          cap_rise,
  input logic          set_hf,
  input logic          wr_ctrl,
  input logic          wr_cnt_lo,
  input logic          wr_cnt_hi,
  input logic          wr_rld_lo,
  input logic          wr_rld_hi,
  input logic [2:0]    bus_addr,
  input logic [7:0]    bus_rdata,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] rld
);
  p_unused_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd0) |-> !bus_rdata[1]);

  p_wrap16_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && run && lo_tick && cnt == '1 && !wr_cnt_lo && !wr_cnt_hi)
    |=> (cnt == $past(rld)));

  p_hi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (split && !run && !wr_cnt_hi) |=> $stable(cnt[CW-1:CW/2]));

  p_hw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_hf |=> hflag);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hflag && !wr_ctrl) |=> hflag);

  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && cap_rise) |=> (rld == $past(cnt)));

  p_no_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !wr_rld_lo && !wr_rld_hi) |=> $stable(rld));

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_global_en |-> !irq);
endmodule

bind split_reload_timer split_reload_timer_chk #(.CW(16)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .irq_global_en(irq_global_en),
  .hflag(ctrl_q.hflag), .split(ctrl_q.split), .run(ctrl_q.run),
  .cap_en(ctrl_q.cap_en), .lo_tick(lo_tick), .cap_rise(cap_rise),
  .set_hf(set_hf), .wr_ctrl(wr_ctrl), .wr_cnt_lo(wr_cnt_lo),
  .wr_cnt_hi(wr_cnt_hi), .wr_rld_lo(wr_rld_lo), .wr_rld_hi(wr_rld_hi),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .cnt(cnt), .rld(rld)
);

// File: tb/split_reload_timer_tb.sv
`timescale 1ns/1ps
module split_reload_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk = 1'b0;
  logic       cmp_in = 1'b0;
  logic       irq_global_en = 1'b0;
  logic       lo_sys_sel = 1'b1;
  logic       hi_sys_sel = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  split_reload_timer dut_i (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .cmp_in(cmp_in),
    .irq_global_en(irq_global_en), .lo_sys_sel(lo_sys_sel),
    .hi_sys_sel(hi_sys_sel), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // external clock: toggles every 3 system cycles (period 6 cycles)
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      ext_clk = ~ext_clk;
    end
  end

  localparam logic [7:0] C_HF = 8'h80, C_LF = 8'h40, C_LIE = 8'h20,
                         C_CAP = 8'h10, C_SPL = 8'h08, C_RUN = 8'h04,
                         C_XS = 8'h01;

  function automatic logic [7:0] step8(logic [7:0] v, logic [7:0] r, int n);
    for (int i = 0; i < n; i++) v = (v == 8'hFF) ? r : v + 8'd1;
    return v;
  endfunction

  function automatic logic [15:0] step16(logic [15:0] v, logic [15:0] r, int n);
    for (int i = 0; i < n; i++) v = (v == 16'hFFFF) ? r : v + 16'd1;
    return v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.1;
    d = bus_rdata;
  endtask

  task automatic rd16(logic [2:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a + 3'd1, hi);
    d = {hi, lo};
  endtask

  // run bit high for exactly n edges (n >= 2)
  task automatic run_for(logic [7:0] base, int n);
    wr(3'd0, base | C_RUN);
    repeat (n - 2) @(negedge clk);
    wr(3'd0, base);
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [7:0] r8;
    logic [15:0] r16, s16, rl16;
    bit seen;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), r8);
      check(r8 == 8'h00, "R1 reset reg", r8, 0);
    end
    check(irq == 1'b0, "R1 reset irq", irq, 0);

    // R2 unused bit reads zero, others read back
    wr(3'd0, 8'h02);
    rd(3'd0, r8);
    check(r8 == 8'h00, "R2 bit1 reads 0", r8, 0);
    wr(3'd0, C_LIE | C_CAP | C_XS);
    rd(3'd0, r8);
    check(r8 == (C_LIE | C_CAP | C_XS), "R2 ctrl readback", r8, C_LIE | C_CAP | C_XS);
    wr(3'd0, 8'h00);

    // R12 register map readback
    wr(3'd1, 8'h12); wr(3'd2, 8'h34); wr(3'd3, 8'h56); wr(3'd4, 8'h78);
    rd16(3'd1, r16);
    check(r16 == 16'h3412, "R12 count map", r16, 16'h3412);
    rd16(3'd3, r16);
    check(r16 == 16'h7856, "R12 reload map", r16, 16'h7856);

    // R3 + R6: 16-bit wrap lands on the stop write edge; hw set wins
    wr(3'd3, 8'h34); wr(3'd4, 8'h12);
    wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
    run_for(8'h00, 2);
    rd16(3'd1, r16);
    check(r16 == 16'h1234, "R3 16-bit reload", r16, 16'h1234);
    rd(3'd0, r8);
    check(r8 == (C_HF | C_LF), "R6 hw set beats write", r8, C_HF | C_LF);
    repeat (50) @(negedge clk);
    rd(3'd0, r8);
    check(r8 == (C_HF | C_LF), "R6 flags sticky", r8, C_HF | C_LF);
    irq_global_en = 1'b1;
    #0.1;
    check(irq == 1'b1, "R8 irq on high flag", irq, 1);
    irq_global_en = 1'b0;
    #0.1;
    check(irq == 1'b0, "R8 irq gated", irq, 0);
    wr(3'd0, 8'h00);
    rd(3'd0, r8);
    check(r8 == 8'h00, "R6 software clear", r8, 0);

    // R3 random 16-bit runs
    for (int k = 0; k < 10; k++) begin
      s16  = (k % 2 == 0) ? {8'hFF, 8'($urandom)} : 16'($urandom);
      rl16 = 16'($urandom);
      wr(3'd3, rl16[7:0]); wr(3'd4, rl16[15:8]);
      wr(3'd1, s16[7:0]);  wr(3'd2, s16[15:8]);
      run_for(8'h00, 2 + int'($urandom % 400));
    end
    // deterministic final random-style run with known length
    s16 = 16'hFFF0; rl16 = 16'h8000;
    wr(3'd3, rl16[7:0]); wr(3'd4, rl16[15:8]);
    wr(3'd1, s16[7:0]);  wr(3'd2, s16[15:8]);
    run_for(8'h00, 37);
    rd16(3'd1, r16);
    check(r16 == step16(s16, rl16, 37), "R3 16-bit steps", r16, step16(s16, rl16, 37));
    for (int k = 0; k < 8; k++) begin
      int n;
      s16  = 16'($urandom);
      if (k < 4) s16[15:8] = 8'hFF;
      rl16 = 16'($urandom);
      n    = 2 + int'($urandom % 500);
      wr(3'd3, rl16[7:0]); wr(3'd4, rl16[15:8]);
      wr(3'd1, s16[7:0]);  wr(3'd2, s16[15:8]);
      run_for(8'h00, n);
      rd16(3'd1, r16);
      check(r16 == step16(s16, rl16, n), "R3 random 16-bit", r16, step16(s16, rl16, n));
    end
    wr(3'd0, 8'h00);

    // R11 write beats increment while running
    wr(3'd0, C_RUN);
    repeat (5) @(negedge clk);
    wr(3'd1, 8'h50);
    rd(3'd1, r8);
    check(r8 == 8'h50, "R11 write over step", r8, 8'h50);
    wr(3'd0, 8'h00);

    // R9 timebase rates
    lo_sys_sel = 1'b0;
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    run_for(8'h00, 120);
    rd16(3'd1, r16);
    check(r16 == 16'd10, "R9 div12 rate", r16, 10);
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    wr(3'd0, C_XS);
    run_for(C_XS, 240);
    rd16(3'd1, r16);
    check(r16 == 16'd5, "R9 ext div8 rate", r16, 5);
    wr(3'd0, 8'h00);
    lo_sys_sel = 1'b1;

    // R4 + R5 + R10 split: high byte random runs
    wr(3'd0, C_SPL);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] h, rh;
      int n;
      h = 8'($urandom); rh = 8'($urandom);
      n = 2 + int'($urandom % 300);
      wr(3'd4, rh); wr(3'd2, h);
      run_for(C_SPL, n);
      rd(3'd2, r8);
      check(r8 == step8(h, rh, n), "R4 split high byte", r8, step8(h, rh, n));
    end
    // low byte counts with run clear; high byte holds (R5)
    wr(3'd0, C_SPL);
    wr(3'd3, 8'h00); wr(3'd2, 8'h33); wr(3'd1, 8'h10);
    repeat (20) @(negedge clk);
    rd(3'd1, r8);
    check(r8 == step8(8'h10, 8'h00, 20), "R5 low runs in split", r8, step8(8'h10, 8'h00, 20));
    rd(3'd2, r8);
    check(r8 == 8'h33, "R5 high held in split", r8, 8'h33);
    for (int k = 0; k < 6; k++) begin
      logic [7:0] l, rl;
      int m;
      l = 8'($urandom); rl = 8'($urandom); m = 1 + int'($urandom % 300);
      wr(3'd3, rl); wr(3'd1, l);
      repeat (m) @(negedge clk);
      rd(3'd1, r8);
      check(r8 == step8(l, rl, m), "R4 split low byte", r8, step8(l, rl, m));
    end

    // R4 low wrap sets only low flag; R8 low enable
    wr(3'd3, 8'h00);
    wr(3'd0, C_SPL);
    wr(3'd1, 8'hFF);
    repeat (3) @(negedge clk);
    rd(3'd0, r8);
    check(r8 == (C_LF | C_SPL), "R4 low flag only", r8, C_LF | C_SPL);
    irq_global_en = 1'b1;
    #0.1;
    check(irq == 1'b0, "R8 low flag masked", irq, 0);
    wr(3'd0, C_LF | C_LIE | C_SPL);
    check(irq == 1'b1, "R8 low flag enabled", irq, 1);
    irq_global_en = 1'b0;
    wr(3'd0, 8'h00);

    // R10 split high on divided timebase while low uses system clock
    hi_sys_sel = 1'b0;
    wr(3'd2, 8'h00); wr(3'd4, 8'h00);
    run_for(C_SPL, 120);
    rd(3'd2, r8);
    check(r8 == 8'd10, "R10 high on timebase", r8, 10);
    hi_sys_sel = 1'b1;
    wr(3'd0, 8'h00);

    // R7 capture with the counter stopped
    wr(3'd1, 8'hCD); wr(3'd2, 8'hAB); wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    wr(3'd0, C_CAP);
    irq_global_en = 1'b1;
    seen = 0;
    @(negedge clk); cmp_in = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (irq) seen = 1;
    end
    rd16(3'd3, r16);
    check(r16 == 16'hABCD, "R7 capture value", r16, 16'hABCD);
    check(seen, "R7 capture irq", seen, 1);
    cmp_in = 1'b0;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h11); wr(3'd2, 8'h11);
    repeat (4) @(negedge clk);
    seen = 0;
    cmp_in = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (irq) seen = 1;
    end
    rd16(3'd3, r16);
    check(r16 == 16'hABCD, "R7 capture disabled", r16, 16'hABCD);
    check(!seen, "R7 no irq when disabled", seen, 0);
    cmp_in = 1'b0;
    irq_global_en = 1'b0;

    finished = 1;
    report();
  end
endmodule